// File: doc/BRIEF.md
# Channel Output Filter and Level Stage

This block is the final digital stage of a four-voice tone generator. Each voice delivers one audio bit per clock. A small control byte comes with each bit, and the block turns the bit into a 4-bit level code that a later summing stage converts to sound. The level code equals the channel's volume field while the effective audio bit is high. It is zero while that bit is low.

Voices 1 and 2 can each pass through a crude high-pass stage. A single held bit samples the voice's audio whenever a tick arrives from a partner voice's frequency divider. The voice's output is then the live audio XOR the held bit. Voice 1 samples on voice 3's tick and voice 2 on voice 4's tick. Two bits of a shared control byte turn these filters on. A force bit in a voice's control byte bypasses the tone path, the filter and the audio entirely. The volume field alone then sets the level.

Every level output is registered, so each result appears one clock after the inputs that produced it. Reset is synchronous and active high.

Top module: `chan_out_stage`

## Requirements
- R1: When a channel's effective audio bit is high, its level output equals bits 3..0 of that channel's control byte. Level 15 (all ones) is the largest code.
- R2: When the effective audio bit is low and the force bit is clear, the level output is 0.
- R3: Bit 4 of a channel's control byte forces the effective audio bit high. The level then equals the volume field whatever the audio input, the tick inputs and the filter state.
- R4: A volume field of 0 gives level 0 in every mode, including force mode.
- R5: Bit 2 of `glb_ctrl` enables the channel 1 filter. While it is enabled, the effective audio is audio_in[0] XOR a held bit, and the held bit takes audio_in[0] on each clock where hp_tick[0] (channel 3's divider pulse) is high.
- R6: Bit 1 of `glb_ctrl` enables the channel 2 filter. It works in the same way with audio_in[1] and hp_tick[1] (channel 4's divider pulse).
- R7: A filter whose enable bit is clear passes the audio unchanged, and the held bit keeps sampling on its tick. Channels 3 and 4 are never filtered, and each tick input affects only its own filter.
- R8: Reset clears all level outputs and both held bits. Ticks seen during reset are not stored.
- R9: Each level output is registered and reflects the inputs from exactly one clock earlier. The held bit used in that result is the value before that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| audio_in | input | 4 | Audio bit per channel, bit 0 = channel 1 |
| hp_tick | input | 2 | Filter sample pulses: bit 0 from channel 3's divider, bit 1 from channel 4's divider |
| ch_ctrl | input | 32 | Control byte per channel, byte 0 = channel 1; bits 3..0 volume, bit 4 force |
| glb_ctrl | input | 8 | Shared control; bit 2 enables the channel 1 filter, bit 1 the channel 2 filter |
| level | output | 16 | Level code per channel, nibble 0 = channel 1 |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit control bytes and 4-bit volume fields. These defaults cover the full filtered and unfiltered channel split and every volume code from 0 to 15. Directed sequences leave a held bit at 1 and then move audio, ticks and enables around it. This makes the XOR inversion, tick routing across channels, the disabled-but-sampling case and the tick-during-reset case visible at the level outputs. A long pseudo-random run then mixes all modes at once against an independent per-cycle model.

// File: rtl/chan_out_pkg.sv
package chan_out_pkg;
  // Number of channels that own a high-pass stage (channels 0..N_FILT-1).
  localparam int unsigned N_FILT = 2;
  // Control byte bit that forces the level-stage input high.
  localparam int unsigned FORCE_BIT = 4;
  // Shared-control bit that enables the filter of filtered channel ch.
  localparam int unsigned EN_TOP = 2;

  function automatic int unsigned hp_en_bit(input int unsigned ch);
    return EN_TOP - ch;
  endfunction
endpackage

// File: rtl/chan_hp_filter.sv
module chan_hp_filter (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic aud_in,
  output logic aud_out
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= 1'b0;
    else if (tick) held_q <= aud_in;
  end

  assign aud_out = en ? (aud_in ^ held_q) : aud_in;
endmodule

// File: rtl/chan_vol_stage.sv
module chan_vol_stage #(
  parameter int unsigned VOL_W  = 4,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aud,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [VOL_W-1:0]  level
);
  import chan_out_pkg::*;

  logic             gate;
  logic [VOL_W-1:0] level_q;
  logic             unused_ctrl;

  assign gate        = ctrl[FORCE_BIT] | aud;
  assign unused_ctrl = ^ctrl[CTRL_W-1:FORCE_BIT+1];

  always_ff @(posedge clk) begin
    if (rst)       level_q <= '0;
    else if (gate) level_q <= ctrl[VOL_W-1:0];
    else           level_q <= '0;
  end

  assign level = level_q;
endmodule

// File: rtl/chan_out_stage.sv
module chan_out_stage #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned VOL_W  = 4,
  parameter int unsigned GLB_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         audio_in,
  input  logic [1:0]                hp_tick,
  input  logic [NUM_CH*CTRL_W-1:0]  ch_ctrl,
  input  logic [GLB_W-1:0]          glb_ctrl,
  output logic [NUM_CH*VOL_W-1:0]   level
);
  import chan_out_pkg::*;

  logic [NUM_CH-1:0] aud_eff;
  logic              unused_glb;

  assign unused_glb = ^glb_ctrl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < N_FILT) begin : g_filt
      chan_hp_filter u_filt (
        .clk     (clk),
        .rst     (rst),
        .en      (glb_ctrl[hp_en_bit(c)]),
        .tick    (hp_tick[c]),
        .aud_in  (audio_in[c]),
        .aud_out (aud_eff[c])
      );
    end else begin : g_pass
      assign aud_eff[c] = audio_in[c];
    end

    chan_vol_stage #(.VOL_W(VOL_W), .CTRL_W(CTRL_W)) u_vol (
      .clk   (clk),
      .rst   (rst),
      .aud   (aud_eff[c]),
      .ctrl  (ch_ctrl[c*CTRL_W +: CTRL_W]),
      .level (level[c*VOL_W +: VOL_W])
    );
  end
endmodule

// File: rtl/chan_out_checker.sv
module chan_out_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned VOL_W  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        audio_in,
  input logic [NUM_CH*CTRL_W-1:0] ch_ctrl,
  input logic [NUM_CH*VOL_W-1:0]  level
);
  import chan_out_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8: reset empties the level register
    p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> level[c*VOL_W +: VOL_W] == '0);

    // R1: output is either silent or the volume field of the previous cycle
    p_level_legal_r1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (level[c*VOL_W +: VOL_W] == '0 ||
                level[c*VOL_W +: VOL_W] == $past(ch_ctrl[c*CTRL_W +: VOL_W])));

    // R3: force bit gives the volume field
    p_force_r3: assert property (@(posedge clk) disable iff (rst)
      ch_ctrl[c*CTRL_W + FORCE_BIT] |=>
        level[c*VOL_W +: VOL_W] == $past(ch_ctrl[c*CTRL_W +: VOL_W]));

    // R4: zero volume silences
    p_zero_vol_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_ctrl[c*CTRL_W +: VOL_W] == '0) |=> level[c*VOL_W +: VOL_W] == '0);

    if (c >= N_FILT) begin : g_unf
      // R2 / R7: unfiltered channel with low audio and no force is silent
      p_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (!audio_in[c] && !ch_ctrl[c*CTRL_W + FORCE_BIT]) |=>
          level[c*VOL_W +: VOL_W] == '0);
    end
  end
endmodule

bind chan_out_stage chan_out_checker #(
  .NUM_CH(NUM_CH), .CTRL_W(CTRL_W), .VOL_W(VOL_W)
) u_chk (
  .clk(clk), .rst(rst), .audio_in(audio_in), .ch_ctrl(ch_ctrl), .level(level)
);

// File: tb/test_chan_out_stage.sv
`timescale 1ns/1ps
module test_chan_out_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  aud = '0;
  logic [1:0]  tick = '0;
  logic [31:0] ctrl = '0;
  logic [7:0]  glb = '0;
  logic [15:0] level;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  held = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  chan_out_stage i_chan_out_stage (
    .clk(clk), .rst(rst), .audio_in(aud), .hp_tick(tick),
    .ch_ctrl(ctrl), .glb_ctrl(glb), .level(level)
  );

  function automatic logic [7:0] cb(input logic [3:0] vol, input logic frc);
    return {3'b000, frc, vol};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: level=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one vector, push the expected result, advance the model.
  task automatic drive(input logic [3:0] a, input logic [1:0] t, input logic [7:0] g,
                       input logic [31:0] c, input string tag);
    logic [15:0] e;
    @(negedge clk);
    aud = a; tick = t; glb = g; ctrl = c;
    for (int ch = 0; ch < 4; ch++) begin
      logic b;
      b = a[ch];
      if (ch < 2 && g[2-ch]) b = b ^ held[ch];
      if (c[ch*8+4]) b = 1'b1;
      e[ch*4 +: 4] = b ? c[ch*8 +: 4] : 4'h0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int ch = 0; ch < 2; ch++) if (t[ch]) held[ch] = a[ch];
  endtask

  // Monitor: compare one clock after each vector, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), level, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: level=%h expected=completion", level);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    // R8: reset with audio high, force set and ticks pulsing
    aud = 4'hF; tick = 2'b11; glb = 8'h06;
    ctrl = {cb(4'hF,1), cb(4'hF,1), cb(4'hF,1), cb(4'hF,1)};
    repeat (3) @(posedge clk);
    #1 check("R8 reset level", level, 16'h0000);
    @(negedge clk); rst = 1'b0; tick = '0; held = '0;

    // R8: held bits were cleared despite ticks during reset -> XOR with 0
    drive(4'b0011, 2'b00, 8'h06, {cb(4'h1,0), cb(4'h2,0), cb(4'h9,0), cb(4'h7,0)}, "R8 held clear");
    // R1 / R2: plain audio patterns, filters off
    drive(4'b1010, 2'b00, 8'h00, {cb(4'hF,0), cb(4'h3,0), cb(4'h5,0), cb(4'hA,0)}, "R1 pattern a");
    drive(4'b0101, 2'b00, 8'h00, {cb(4'hF,0), cb(4'h3,0), cb(4'h5,0), cb(4'hA,0)}, "R2 pattern b");
    drive(4'b0000, 2'b00, 8'h00, {cb(4'hF,0), cb(4'hF,0), cb(4'hF,0), cb(4'hF,0)}, "R2 all low");
    drive(4'b1111, 2'b00, 8'h00, {cb(4'hF,0), cb(4'hF,0), cb(4'hF,0), cb(4'hF,0)}, "R1 max level");
    // R3: force with audio low, ticks and filters active
    drive(4'b0000, 2'b11, 8'h06, {cb(4'h4,1), cb(4'hC,1), cb(4'h8,1), cb(4'h6,1)}, "R3 force");
    // R4: zero volume, forced and audio high
    drive(4'b1111, 2'b00, 8'h06, {cb(4'h0,1), cb(4'h0,0), cb(4'h0,1), cb(4'h0,0)}, "R4 zero vol");
    // R5: load channel 1 held bit with 1 via tick from channel 3 divider
    drive(4'b0001, 2'b01, 8'h04, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hB,0)}, "R5 sample");
    drive(4'b0001, 2'b00, 8'h04, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hB,0)}, "R5 cancel");
    drive(4'b0000, 2'b00, 8'h04, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hB,0)}, "R5 invert");
    // R7: channel 2 tick does not touch channel 1; ch1 held stays 1
    drive(4'b0010, 2'b10, 8'h04, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hD,0)}, "R7 tick routing");
    // R6: channel 2 held now 1 -> cancels with audio high
    drive(4'b0010, 2'b00, 8'h02, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hD,0)}, "R6 cancel");
    drive(4'b0000, 2'b00, 8'h02, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hD,0)}, "R6 invert");
    // R7: disabled filter passes audio though held bits are 1; keeps sampling
    drive(4'b0000, 2'b11, 8'h00, {cb(4'h1,0), cb(4'h2,0), cb(4'h3,0), cb(4'hD,0)}, "R7 bypass");
    drive(4'b0011, 2'b00, 8'h06, {cb(4'h6,0), cb(4'h9,0), cb(4'h3,0), cb(4'hD,0)}, "R7 sampled while off");
    // R9: single-cycle pulse appears exactly one cycle later
    drive(4'b0100, 2'b00, 8'h00, {cb(4'h0,0), cb(4'h0,0), cb(4'hE,0), cb(4'h0,0)}, "R9 pulse");
    drive(4'b0000, 2'b00, 8'h00, {cb(4'h0,0), cb(4'h0,0), cb(4'hE,0), cb(4'h0,0)}, "R9 pulse end");
    // Mixed pseudo-random run
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3:0], lfsr[5:4], {5'b0, lfsr[7:6], 1'b0},
            {lfsr[31:8], lfsr[15:8]} & 32'h1F1F1F1F, "R1 mixed");
    end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule